// File: doc/BRIEF.md
# Wide-Key Ternary Search Pipeline

This block is a small ternary search table for 272-bit keys. Each wide entry is made of four consecutive 68-bit storage words, which together form one page. Every storage word holds a data value and a per-bit care mask. A table-wide mask register can also exclude key bits from every comparison. A search command compares the key against all wide entries in one pass. The lowest-numbered wide entry that matches wins. The block reports that entry as a narrow-word memory address, which is always aligned to a page.

The result path is a fixed pipeline. A search may be accepted at most once every four cycles. Two configuration inputs set the timing of the result:

- A 2-bit size field sets how many cycles after acceptance the address appears.
- A 3-bit skew field delays the valid and found strobes further behind the address.

A tail flag marks the device that owns the memory-enable output. Only when that flag is set does a hit drive the enable. The configuration inputs must be held steady while a search is in flight.

Top module: `tcam_wide_search`

## Requirements
- R1: When several wide entries match, the lowest index e wins, and `mem_addr` becomes e*4, so its two low bits are always 00.
- R2: A key bit matches a stored bit when the care bit is 0 or the two bits are equal. Storage word 4e+j of wide entry e compares against key bits [68j+67:68j].
- R3: A global-mask bit at 1 removes that key bit from every comparison. The mask is written with `wr_gmask`=1: `wr_data` is written into slice `wr_addr[1:0]`, which covers key bits [68j+67:68j], and `wr_care` is ignored.
- R4: A wide entry takes part in searches only after all four of its words have been written since reset.
- R5: A command is taken only while `cmd_ready` is high. After an acceptance, `cmd_ready` stays low for the next 3 cycles, and commands presented during that time are ignored.
- R6: The address is updated at the 4th, 5th or 6th clock edge after the accepting edge, for `cfg_tlsz` = 00, 01 or 10 respectively. The value 11 behaves like 10.
- R7: `srch_valid` is a one-cycle pulse that comes `cfg_hlat` (0 to 7) cycles after the address update.
- R8: On a miss, `srch_valid` pulses with `srch_found` low, `mem_addr` keeps its previous value and `mem_en` stays low.
- R9: On a hit, `mem_en` pulses for one cycle together with the address update, but only when `cfg_tail` is 1.
- R10: A write at an edge before the accepting edge is visible to that search. A write at the accepting edge itself is not visible to it.
- R11: During and right after reset, `mem_addr`, `mem_en`, `srch_valid` and `srch_found` are 0, `cmd_ready` is 1, no entry is valid and the global mask is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tlsz | input | 2 | Size field that selects the address latency |
| cfg_hlat | input | 3 | Extra strobe delay behind the address |
| cfg_tail | input | 1 | This device drives memory enable |
| wr_en | input | 1 | Write strobe |
| wr_gmask | input | 1 | 1: write a global-mask slice; 0: write a storage word |
| wr_addr | input | 6 | Storage word index, or mask slice in bits [1:0] |
| wr_data | input | 68 | Data word, or mask slice value |
| wr_care | input | 68 | Per-bit care mask for a storage word |
| cmd_valid | input | 1 | Search request |
| cmd_key | input | 272 | Search key |
| cmd_ready | output | 1 | A request is taken this cycle |
| mem_addr | output | 6 | Page-aligned winning word address |
| mem_en | output | 1 | Memory enable pulse on a hit |
| srch_valid | output | 1 | Search result strobe |
| srch_found | output | 1 | Search hit strobe |

## Verification
A wrong validity bit or a wrong stored bit shows up as a found strobe for the wrong page, or as a missing found strobe. A wrong priority choice shows up as a wrong address. Either error appears at the address output exactly at the configured latency. A fault in the delay taps shifts the address or the strobes by one or more cycles against the expected edge. A fault in the acceptance counter shows up the cycle after it happens, because `cmd_ready` then disagrees with the expected state. The reference model is checked against every output on every clock, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int unsigned PAGE_WORDS = 4;
  localparam int unsigned MAX_LAT    = 6;
  localparam int unsigned MAX_HLAT   = 7;
  localparam int unsigned PIPE_DEPTH = MAX_LAT + MAX_HLAT - 1;

  // Address latency in edges after the accepting edge.
  function automatic int unsigned lat_of_size(input logic [1:0] sz);
    case (sz)
      2'b00:   return 4;
      2'b01:   return 5;
      default: return 6;
    endcase
  endfunction

  // Pipe tap for the address: two stages sit ahead of the shift line.
  function automatic int unsigned addr_tap(input logic [1:0] sz);
    return lat_of_size(sz) - 2;
  endfunction

  function automatic int unsigned strobe_tap(input logic [1:0] sz, input logic [2:0] hl);
    return addr_tap(sz) + int'(hl);
  endfunction
endpackage

// File: rtl/tcam_store.sv
module tcam_store import tcam_pkg::*; #(
  parameter int unsigned WORD_W  = 68,
  parameter int unsigned N_ENTRY = 16
)(
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic                                   wr_gmask,
  input  logic [$clog2(N_ENTRY*PAGE_WORDS)-1:0]  wr_addr,
  input  logic [WORD_W-1:0]                      wr_data,
  input  logic [WORD_W-1:0]                      wr_care,
  input  logic [WORD_W*PAGE_WORDS-1:0]           key,
  output logic [N_ENTRY-1:0]                     hit_vec
);
  localparam int unsigned N_WORD = N_ENTRY * PAGE_WORDS;

  logic [WORD_W-1:0] data_q [N_WORD];
  logic [WORD_W-1:0] care_q [N_WORD];
  logic [N_WORD-1:0] vld_q;
  logic [WORD_W-1:0] gmask_q [PAGE_WORDS];

  wire word_wr = wr_en && !wr_gmask;
  wire mask_wr = wr_en &&  wr_gmask;

  always_ff @(posedge clk) begin
    if (word_wr) begin
      data_q[wr_addr] <= wr_data;
      care_q[wr_addr] <= wr_care;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int p = 0; p < int'(PAGE_WORDS); p++) gmask_q[p] <= '0;
    end else begin
      if (word_wr) vld_q[wr_addr] <= 1'b1;
      if (mask_wr) gmask_q[wr_addr[1:0]] <= wr_data;
    end
  end

  for (genvar e = 0; e < int'(N_ENTRY); e++) begin : g_ent
    logic [PAGE_WORDS-1:0] w_ok;
    for (genvar p = 0; p < int'(PAGE_WORDS); p++) begin : g_word
      localparam int unsigned W = e * PAGE_WORDS + p;
      assign w_ok[p] = vld_q[W] &&
        ~|((key[p*WORD_W +: WORD_W] ^ data_q[W]) & care_q[W] & ~gmask_q[p]);
    end
    assign hit_vec[e] = &w_ok;
  end

  // R4
  page_needs_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q == '0) |-> (hit_vec == '0));
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int unsigned N_ENTRY = 16
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [N_ENTRY-1:0]         in_vec,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic [$clog2(N_ENTRY)-1:0] res_idx
);
  localparam int unsigned IDX_W = $clog2(N_ENTRY);
  localparam logic [N_ENTRY-1:0] ONE = 1;

  logic               a_valid;
  logic [N_ENTRY-1:0] a_vec;
  logic               enc_hit;
  logic [IDX_W-1:0]   enc_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_vec   <= '0;
    end else begin
      a_valid <= in_valid;
      a_vec   <= in_valid ? in_vec : '0;
    end
  end

  always_comb begin
    enc_hit = 1'b0;
    enc_idx = '0;
    for (int i = int'(N_ENTRY) - 1; i >= 0; i--) begin
      if (a_vec[i]) begin
        enc_hit = 1'b1;
        enc_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= a_valid;
      res_hit   <= a_valid && enc_hit;
      res_idx   <= enc_idx;
    end
  end

  // R1
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && (a_vec != '0)) |=>
      (res_hit && (($past(a_vec) & ((ONE << res_idx) - ONE)) == '0) &&
       ((($past(a_vec) >> res_idx) & ONE) == ONE)));

  // R8
  miss_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && (a_vec == '0)) |=> (res_valid && !res_hit));
endmodule

// File: rtl/tcam_delay.sv
module tcam_delay import tcam_pkg::*; #(
  parameter int unsigned IDX_W = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_tlsz,
  input  logic [2:0]       cfg_hlat,
  input  logic             cfg_tail,
  input  logic             res_valid,
  input  logic             res_hit,
  input  logic [IDX_W-1:0] res_idx,
  output logic [IDX_W+1:0] mem_addr,
  output logic             mem_en,
  output logic             srch_valid,
  output logic             srch_found
);
  localparam int unsigned D     = PIPE_DEPTH;
  localparam int unsigned TAP_W = $clog2(D);

  logic [D-2:0]     sh_v, sh_h;
  logic [IDX_W-1:0] sh_i [D-1];
  logic [D-1:0]     all_v, all_h;
  logic [IDX_W-1:0] all_i [D];
  logic [TAP_W-1:0] a_tap, s_tap;
  logic             tap_av, tap_ah, tap_sv, tap_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_v <= '0;
      sh_h <= '0;
    end else begin
      sh_v <= {sh_v[D-3:0], res_valid};
      sh_h <= {sh_h[D-3:0], res_valid && res_hit};
    end
  end

  always_ff @(posedge clk) begin
    sh_i[0] <= res_idx;
    for (int k = 1; k < int'(D) - 1; k++) sh_i[k] <= sh_i[k-1];
  end

  assign all_v = {sh_v, res_valid};
  assign all_h = {sh_h, res_valid && res_hit};
  assign all_i[0] = res_idx;
  for (genvar k = 1; k < int'(D); k++) begin : g_tap
    assign all_i[k] = sh_i[k-1];
  end

  assign a_tap  = TAP_W'(addr_tap(cfg_tlsz));
  assign s_tap  = TAP_W'(strobe_tap(cfg_tlsz, cfg_hlat));
  assign tap_av = all_v[a_tap];
  assign tap_ah = all_h[a_tap];
  assign tap_sv = all_v[s_tap];
  assign tap_sh = all_h[s_tap];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_en     <= 1'b0;
      srch_valid <= 1'b0;
      srch_found <= 1'b0;
    end else begin
      mem_en     <= 1'b0;
      srch_valid <= tap_sv;
      srch_found <= tap_sv && tap_sh;
      if (tap_av && tap_ah) begin
        mem_addr <= {all_i[a_tap], 2'b00};
        mem_en   <= cfg_tail;
      end
    end
  end

  // R7
  found_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_found |-> srch_valid);

  // R8
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_av && !tap_ah) |=> ($stable(mem_addr) && !mem_en));

  // R9
  en_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> cfg_tail);

  // R9
  en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && cfg_hlat == 3'd0) |-> srch_found);
endmodule

// File: rtl/tcam_wide_search.sv
module tcam_wide_search import tcam_pkg::*; #(
  parameter int unsigned KEY_W   = 272,
  parameter int unsigned N_ENTRY = 16
)(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [1:0]                            cfg_tlsz,
  input  logic [2:0]                            cfg_hlat,
  input  logic                                  cfg_tail,
  input  logic                                  wr_en,
  input  logic                                  wr_gmask,
  input  logic [$clog2(N_ENTRY*PAGE_WORDS)-1:0] wr_addr,
  input  logic [KEY_W/PAGE_WORDS-1:0]           wr_data,
  input  logic [KEY_W/PAGE_WORDS-1:0]           wr_care,
  input  logic                                  cmd_valid,
  input  logic [KEY_W-1:0]                      cmd_key,
  output logic                                  cmd_ready,
  output logic [$clog2(N_ENTRY*PAGE_WORDS)-1:0] mem_addr,
  output logic                                  mem_en,
  output logic                                  srch_valid,
  output logic                                  srch_found
);
  localparam int unsigned WORD_W = KEY_W / PAGE_WORDS;
  localparam int unsigned EIDX_W = $clog2(N_ENTRY);
  localparam int unsigned GAP    = PAGE_WORDS - 1;
  localparam int unsigned CW     = $clog2(PAGE_WORDS);

  logic [CW-1:0]      cool_q;
  logic               accept;
  logic [N_ENTRY-1:0] hit_vec;
  logic               res_valid, res_hit;
  logic [EIDX_W-1:0]  res_idx;

  assign cmd_ready = (cool_q == '0);
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)               cool_q <= '0;
    else if (accept)          cool_q <= CW'(GAP);
    else if (cool_q != '0)    cool_q <= cool_q - 1'b1;
  end

  tcam_store #(.WORD_W(WORD_W), .N_ENTRY(N_ENTRY)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_gmask(wr_gmask),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_care(wr_care),
    .key(cmd_key), .hit_vec(hit_vec)
  );

  tcam_prio #(.N_ENTRY(N_ENTRY)) prio_i (
    .clk(clk), .rst_n(rst_n), .in_valid(accept), .in_vec(hit_vec),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
  );

  tcam_delay #(.IDX_W(EIDX_W)) delay_i (
    .clk(clk), .rst_n(rst_n), .cfg_tlsz(cfg_tlsz), .cfg_hlat(cfg_hlat),
    .cfg_tail(cfg_tail), .res_valid(res_valid), .res_hit(res_hit),
    .res_idx(res_idx), .mem_addr(mem_addr), .mem_en(mem_en),
    .srch_valid(srch_valid), .srch_found(srch_found)
  );

  // R5
  accept_gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  // R5
  accept_gap3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##2 !accept);

  // R5
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##3 cmd_ready);
endmodule

// File: tb/tcam_wide_search_tb_top.sv
module tcam_wide_search_tb_top;
  localparam int KEY_W = 272, N_ENTRY = 16, WORD_W = 68, N_WORD = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] cfg_tlsz = 2'b01;
  logic [2:0] cfg_hlat = 3'd0;
  logic cfg_tail = 1'b1;
  logic wr_en = 1'b0, wr_gmask = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [WORD_W-1:0] wr_data = '0, wr_care = '0;
  logic cmd_valid = 1'b0;
  logic [KEY_W-1:0] cmd_key = '0;
  logic cmd_ready, mem_en, srch_valid, srch_found;
  logic [5:0] mem_addr;

  tcam_wide_search dut_i (.*);

  int checks = 0, fails = 0, cyc = 0, cool = 0, sv_count = 0;
  logic [WORD_W-1:0] m_data [N_WORD];
  logic [WORD_W-1:0] m_care [N_WORD];
  bit m_vld [N_WORD];
  logic [WORD_W-1:0] m_gm [4];
  int exp_addr = 0;
  int ev_ai [int];
  bit ev_sv [int];
  bit ev_sf [int];
  logic [KEY_W-1:0] ekey [N_ENTRY];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  function automatic int ref_scan(logic [KEY_W-1:0] k);
    for (int e = 0; e < N_ENTRY; e++) begin
      bit ok = 1;
      for (int j = 0; j < 4; j++) begin
        int w = e * 4 + j;
        if (!m_vld[w] || (((k[j*WORD_W +: WORD_W] ^ m_data[w]) & m_care[w] & ~m_gm[j]) != '0))
          ok = 0;
      end
      if (ok) return e;
    end
    return -1;
  endfunction

  function automatic logic [WORD_W-1:0] rw();
    return WORD_W'({$urandom(), $urandom(), $urandom()});
  endfunction

  task automatic check_outputs();
    bit e_en = 0;
    bit e_sf;
    if (ev_ai.exists(cyc)) begin exp_addr = ev_ai[cyc]; e_en = cfg_tail; end
    e_sf = ev_sf.exists(cyc) && ev_sf[cyc];
    chk(mem_addr == 6'(exp_addr), "R6", "mem_addr", int'(mem_addr), exp_addr);
    chk(mem_en == e_en, "R9", "mem_en", int'(mem_en), int'(e_en));
    chk(srch_valid == ev_sv.exists(cyc), "R7", "srch_valid", int'(srch_valid), int'(ev_sv.exists(cyc)));
    chk(srch_found == e_sf, "R8", "srch_found", int'(srch_found), int'(e_sf));
    chk(cmd_ready == (cool == 0), "R5", "cmd_ready", int'(cmd_ready), int'(cool == 0));
    if (srch_valid) sv_count++;
  endtask

  task automatic tick();
    int c = cyc + 1;
    if (!rst_n) begin
      cool = 0; exp_addr = 0;
      for (int w = 0; w < N_WORD; w++) m_vld[w] = 0;
      for (int j = 0; j < 4; j++) m_gm[j] = '0;
    end else begin
      if (cmd_valid && cool == 0) begin
        int r = ref_scan(cmd_key);
        int lat = (cfg_tlsz == 2'b00) ? 4 : (cfg_tlsz == 2'b01) ? 5 : 6;
        if (r >= 0) ev_ai[c + lat] = r * 4;
        ev_sv[c + lat + int'(cfg_hlat)] = 1;
        ev_sf[c + lat + int'(cfg_hlat)] = (r >= 0);
        cool = 3;
      end else if (cool > 0) cool--;
      if (wr_en && wr_gmask) m_gm[wr_addr[1:0]] = wr_data;
      else if (wr_en) begin
        m_data[wr_addr] = wr_data; m_care[wr_addr] = wr_care; m_vld[wr_addr] = 1;
      end
    end
    @(posedge clk);
    cyc = c;
    #3;
    check_outputs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_word(int a, logic [WORD_W-1:0] d, logic [WORD_W-1:0] cm);
    wr_en = 1; wr_gmask = 0; wr_addr = 6'(a); wr_data = d; wr_care = cm;
    tick();
    wr_en = 0;
  endtask

  task automatic wr_gm(int s, logic [WORD_W-1:0] v);
    wr_en = 1; wr_gmask = 1; wr_addr = 6'(s); wr_data = v; wr_care = '0;
    tick();
    wr_en = 0; wr_gmask = 0;
  endtask

  // Issue one search, wait for its result and compare with an intended index.
  task automatic search(logic [KEY_W-1:0] k, int want, string req);
    bit seen = 0;
    chk(ref_scan(k) == want, req, "model index", ref_scan(k), want);
    cmd_key = k; cmd_valid = 1;
    tick();
    cmd_valid = 0;
    for (int i = 0; i < 16; i++) begin
      tick();
      if (srch_found) seen = 1;
    end
    chk(seen == (want >= 0), req, "found seen", int'(seen), int'(want >= 0));
    if (want >= 0) chk(mem_addr == 6'(want * 4), req, "winner addr", int'(mem_addr), want * 4);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [KEY_W-1:0] k;
    // R11: reset state
    idle(3);
    rst_n = 1;
    idle(2);
    chk(cmd_ready == 1 && mem_addr == 0 && !srch_valid, "R11", "reset state",
        int'({cmd_ready, srch_valid}), 2);

    // R2 R4: program 15 complete pages, page 15 with three words only
    for (int e = 0; e < N_ENTRY; e++) begin
      for (int j = 0; j < 4; j++) ekey[e][j*WORD_W +: WORD_W] = rw();
      for (int j = 0; j < 4; j++)
        if (!(e == 15 && j == 3)) wr_word(e * 4 + j, ekey[e][j*WORD_W +: WORD_W], '1);
    end
    search(ekey[5], 5, "R2");
    k = ekey[5]; k[0] = ~k[0];
    search(k, -1, "R8");
    search(ekey[15], -1, "R4");
    // R10: last word written, search accepted the next edge
    wr_word(63, ekey[15][3*WORD_W +: WORD_W], '1);
    cmd_key = ekey[15]; cmd_valid = 1; tick(); cmd_valid = 0; idle(16);
    search(ekey[15], 15, "R10");

    // R1: duplicate page, lowest wins
    for (int j = 0; j < 4; j++) wr_word(9 * 4 + j, ekey[3][j*WORD_W +: WORD_W], '1);
    search(ekey[3], 3, "R1");

    // R2: don't-care slice in page 7
    wr_word(7 * 4 + 2, ekey[7][2*WORD_W +: WORD_W], '0);
    k = ekey[7]; k[2*WORD_W +: WORD_W] = ~k[2*WORD_W +: WORD_W];
    search(k, 7, "R2");

    // R3: global mask slice 0
    k = ekey[5]; k[WORD_W-1:0] = ~k[WORD_W-1:0];
    search(k, -1, "R3");
    wr_gm(0, '1);
    search(k, 5, "R3");
    wr_gm(0, '0);
    search(k, -1, "R3");

    // R10: write on the accepting edge is not seen by that search
    k = ekey[12]; k[5] = ~k[5];
    wr_en = 1; wr_gmask = 0; wr_addr = 6'(48); wr_data = k[WORD_W-1:0]; wr_care = '1;
    cmd_key = k; cmd_valid = 1;
    tick();
    wr_en = 0; cmd_valid = 0;
    idle(16);
    search(k, 12, "R10");

    // R5: held request is taken only every fourth cycle
    sv_count = 0;
    cmd_key = ekey[5]; cmd_valid = 1;
    idle(8);
    cmd_valid = 0;
    idle(20);
    chk(sv_count == 2, "R5", "results from held request", sv_count, 2);

    // R6 R7: latency settings
    for (int t = 0; t < 4; t++) begin
      for (int h = 0; h < 8; h += 3) begin
        cfg_tlsz = 2'(t); cfg_hlat = 3'(h);
        idle(2);
        search(ekey[5], 5, "R6");
        search(ekey[0], 0, "R7");
      end
    end
    cfg_tlsz = 2'b01; cfg_hlat = 3'd7;
    idle(2);
    search(ekey[14], 14, "R7");

    // R9: no enable when not the tail
    cfg_tail = 0; cfg_hlat = 0;
    idle(2);
    search(ekey[6], 6, "R9");
    cfg_tail = 1;
    idle(2);

    // R11: reset again clears validity and mask
    wr_gm(1, '1);
    rst_n = 0; idle(2); rst_n = 1; idle(1);
    chk(mem_addr == 0 && cmd_ready, "R11", "after second reset", int'(mem_addr), 0);
    search(ekey[5], -1, "R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule